// File: doc/BRIEF.md
# Audio Codec Control Register Bank

This block is the indexed control register file of an audio codec. A host reaches it through a plain word port. The port has a 7-bit index, 16-bit write data, a write strobe, a read strobe and registered read data. The file holds six volume and mute registers:

- stereo master output
- mono master output
- beep
- phone input
- microphone input
- line input

Each register keeps only its defined fields. Every other bit reads as zero.

Index 00h is special. A write of any value to it puts every register back to its default. A read of it returns a fixed capability code, set by a parameter. The low index bit is ignored, so an odd index reaches the even register just below it. Indices that hold no register drop writes and read back as zero.

The 5-bit input gain fields move 1.5 dB per code step. Code 00000 is +12 dB and code 01000 is 0 dB. The input registers leave reset at the 0 dB code with mute set.

Top module: `acr_regbank`

## Requirements
- R1: After rst_n is released, the registers hold these defaults: 02h=8000h, 06h=8000h, 0Ah=0000h, 0Ch=8008h, 0Eh=8008h, 10h=8808h.
- R2: A write of any data value to index 00h (or 01h) returns every register to its R1 default, starting with the next clock.
- R3: A read of index 00h (or 01h) returns the parameter CAP_CODE (default 0140h), whatever has been written there.
- R4: Index bit 0 is ignored for both reads and writes, so index 2k+1 is the same location as 2k.
- R5: Field layout, with bit 15 as the mute flag (1 = muted) in every register:
  - 02h: left attenuation [13:8], right attenuation [5:0].
  - 06h: attenuation [4:0].
  - 0Ah: beep attenuation [3:0], 3 dB per step.
  - 0Ch: gain [4:0].
  - 0Eh: gain [4:0], plus a 20 dB boost enable at bit 6 (1 = on).
  - 10h: left gain [12:8], right gain [4:0].
  - All other bits read 0 and ignore writes.
- R6: A write to an index holding no register changes no register, and a read of such an index returns 0000h.
- R7: rdata updates on the clock edge that samples rd_en, so it is valid one clock after the strobe. While rd_en is low, rdata holds its value. After reset, rdata is 0000h.
- R8: When a read and a write to the same register fall in the same cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx | input | 7 | Register index |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Registered read data |

## Verification
The bench builds the block with its default parameters: a 7-bit index, a 16-bit word and a capability code of 0140h. With a 7-bit index, the whole index space can be swept. Every one of the 128 indices is written once with a varying pattern. After each write, all 128 indices are read back against a model in the bench. That model keeps its own field masks and defaults. The sweep therefore covers aliasing, reserved bits, empty locations and the reset index. Directed steps add the read-data hold behaviour and a read colliding with a write in the same cycle.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 16;
  localparam int NREG   = 6;
  localparam int MUTE_BIT = 15;

  // Even index of implemented register slot i
  function automatic logic [IDX_W-1:0] slot_index(input int i);
    case (i)
      0: slot_index = 7'h02;
      1: slot_index = 7'h06;
      2: slot_index = 7'h0A;
      3: slot_index = 7'h0C;
      4: slot_index = 7'h0E;
      default: slot_index = 7'h10;
    endcase
  endfunction

  // Build a mask of 'width' ones starting at bit 'lsb'
  function automatic logic [DATA_W-1:0] field(input int lsb, input int width);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W; b++)
      if (b >= lsb && b < lsb + width) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] slot_mask(input int i);
    logic [DATA_W-1:0] mute;
    mute = field(MUTE_BIT, 1);
    case (i)
      0: slot_mask = mute | field(8, 6) | field(0, 6);
      1: slot_mask = mute | field(0, 5);
      2: slot_mask = mute | field(0, 4);
      3: slot_mask = mute | field(0, 5);
      4: slot_mask = mute | field(6, 1) | field(0, 5);
      default: slot_mask = mute | field(8, 5) | field(0, 5);
    endcase
  endfunction

  // 5-bit gain code for a gain given in half-dB units (+12 dB -> 0)
  function automatic logic [4:0] gain_code(input int half_db);
    gain_code = 5'((24 - half_db) / 3);
  endfunction

  function automatic logic [DATA_W-1:0] slot_default(input int i);
    logic [4:0] zero_db;
    zero_db = gain_code(0);
    case (i)
      0: slot_default = 16'h8000;
      1: slot_default = 16'h8000;
      2: slot_default = 16'h0000;
      3: slot_default = 16'h8000 | 16'(zero_db);
      4: slot_default = 16'h8000 | 16'(zero_db);
      default: slot_default = 16'h8000 | (16'(zero_db) << 8) | 16'(zero_db);
    endcase
  endfunction

  // Drop bit 0: odd indices reach the even location below
  function automatic logic [IDX_W-1:0] fold_index(input logic [IDX_W-1:0] idx);
    fold_index = {idx[IDX_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/acr_index_decode.sv
module acr_index_decode
  import acr_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] eff_idx,
  output logic [NREG-1:0]  sel,
  output logic             reset_hit,
  output logic             any_hit
);
  assign eff_idx   = fold_index(idx);
  assign reset_hit = (eff_idx == '0);

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign sel[g] = (eff_idx == slot_index(g));
  end

  assign any_hit = |sel;

  // Odd and even index of a pair must decode alike
  always_comb begin
    if (idx[0]) AST_ALIAS_SAME: assert (eff_idx == (idx - 7'd1)); // R4
    AST_SEL_ONEHOT: assert ($onehot0(sel)); // R4
  end
endmodule

// File: rtl/acr_ctrl_reg.sv
module acr_ctrl_reg
  import acr_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = '1,
  parameter logic [DATA_W-1:0] DEFV = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= DEFV;
    else if (clr) q <= DEFV;
    else if (we)  q <= wdata & MASK;
  end

  AST_CLR_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> q == DEFV); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !we) |=> $stable(q)); // R6
  AST_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> q == ($past(wdata) & MASK)); // R5
endmodule

// File: rtl/acr_read_port.sv
module acr_read_port
  import acr_pkg::*;
#(
  parameter logic [DATA_W-1:0] CAP_CODE = 16'h0140
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic                        reset_hit,
  input  logic [NREG-1:0]             sel,
  input  logic [NREG-1:0][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]           rdata
);
  logic [DATA_W-1:0] mux_out;

  always_comb begin
    mux_out = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) mux_out = mux_out | regs[i];
    if (reset_hit) mux_out = CAP_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= mux_out;
  end

  AST_CAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reset_hit) |=> rdata == CAP_CODE); // R3
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !reset_hit && sel == '0) |=> rdata == '0); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R7
endmodule

// File: rtl/acr_regbank.sv
module acr_regbank
  import acr_pkg::*;
#(
  parameter logic [DATA_W-1:0] CAP_CODE = 16'h0140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        idx,
  input  logic [15:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [15:0]       rdata
);
  logic [IDX_W-1:0]            eff_idx;
  logic [NREG-1:0]             sel;
  logic                        reset_hit;
  logic                        any_hit;
  logic                        clr_all;
  logic [NREG-1:0][DATA_W-1:0] regs;

  acr_index_decode u_dec (
    .idx       (idx),
    .eff_idx   (eff_idx),
    .sel       (sel),
    .reset_hit (reset_hit),
    .any_hit   (any_hit)
  );

  assign clr_all = wr_en && reset_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    acr_ctrl_reg #(
      .MASK (slot_mask(g)),
      .DEFV (slot_default(g))
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_all),
      .we    (wr_en && sel[g]),
      .wdata (wdata),
      .q     (regs[g])
    );
  end

  acr_read_port #(.CAP_CODE(CAP_CODE)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .reset_hit (reset_hit),
    .sel       (sel),
    .regs      (regs),
    .rdata     (rdata)
  );

  // Read colliding with a write returns the pre-write value
  AST_RW_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && any_hit) |=> rdata == $past(regs[0] & {DATA_W{sel[0]}} |
      regs[1] & {DATA_W{sel[1]}} | regs[2] & {DATA_W{sel[2]}} |
      regs[3] & {DATA_W{sel[3]}} | regs[4] & {DATA_W{sel[4]}} |
      regs[5] & {DATA_W{sel[5]}})); // R8
endmodule

// File: tb/tb_acr_regbank.sv
`timescale 1ns/1ps
module tb_acr_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  idx = '0;
  logic [15:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rdata;

  int nchk = 0;
  int nbad = 0;
  int cyc = 0;
  logic [15:0] model [64];

  localparam logic [15:0] CAP = 16'h0140;

  acr_regbank dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nbad++;
      $display("FAIL watchdog: expired, actual %0d cycles, expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  // Bench view of the map: allowed bits per even index (0 = no register)
  function automatic logic [15:0] keep_bits(input int e);
    case (e)
      2:  return 16'h8000 | 16'h3F00 | 16'h003F;
      6:  return 16'h8000 | 16'h001F;
      10: return 16'h8000 | 16'h000F;
      12: return 16'h8000 | 16'h001F;
      14: return 16'h8000 | 16'h0040 | 16'h001F;
      16: return 16'h8000 | 16'h1F00 | 16'h001F;
      default: return 16'h0000;
    endcase
  endfunction

  // 0 dB code: (12 dB / 1.5 dB) steps below the +12 dB code 0
  function automatic logic [15:0] dflt(input int e);
    logic [15:0] z;
    z = 16'(12 * 2 / 3);
    case (e)
      2, 6:   return 16'h8000;
      12, 14: return 16'h8000 + z;
      16:     return 16'h8000 + (z << 8) + z;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_reset();
    for (int e = 0; e < 64; e++) model[e] = dflt(2 * e);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] i, input logic [15:0] d);
    @(negedge clk);
    idx = i; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (i[6:1] == 0) model_reset();
    else model[i[6:1]] = d & keep_bits(2 * int'(i[6:1]));
  endtask

  task automatic do_read(input logic [6:0] i, output logic [15:0] v);
    @(negedge clk);
    idx = i; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  function automatic string tag_of(input logic [6:0] i);
    int e;
    e = 2 * int'(i[6:1]);
    if (e == 0) return i[0] ? "R3/R4" : "R3";
    if (keep_bits(e) == 0) return i[0] ? "R6/R4" : "R6";
    return i[0] ? "R5/R4" : "R5";
  endfunction

  function automatic logic [15:0] expect_rd(input logic [6:0] i);
    if (i[6:1] == 0) return CAP;
    return model[i[6:1]];
  endfunction

  initial begin
    logic [15:0] v;
    logic [15:0] hold;
    model_reset();
    repeat (3) @(negedge clk);
    check("R7", rdata, 16'h0000);
    rst_n = 1'b1;

    // R1: defaults on every index after reset
    for (int i = 0; i < 128; i++) begin
      do_read(7'(i), v);
      check(i[6:1] == 0 ? "R3" : "R1", v, expect_rd(7'(i)));
    end

    // R7: rdata held while rd_en low
    hold = rdata;
    repeat (4) @(negedge clk);
    idx = 7'h02;
    check("R7", rdata, hold);

    // Sweep: write each index once, then read back all indices
    for (int w = 0; w < 128; w++) begin
      logic [15:0] pat;
      pat = (w % 5 == 0) ? 16'hFFFF : 16'((w * 16'h9E37) ^ 16'h5A5A);
      if (w < 2) pat = 16'h0000;
      do_write(7'(w), pat);
      for (int r = 0; r < 128; r++) begin
        do_read(7'(r), v);
        check(tag_of(7'(r)), v, expect_rd(7'(r)));
      end
    end

    // R2: reset index write restores defaults after values were changed
    do_write(7'h0E, 16'h7FFF);
    do_write(7'h03, 16'h1234);
    do_write(7'h01, 16'hBEEF);
    for (int e = 2; e <= 16; e += 2) begin
      do_read(7'(e), v);
      check("R2", v, dflt(e));
    end

    // R8: read and write to the same register in one cycle
    do_write(7'h0C, 16'h0011);
    @(negedge clk);
    idx = 7'h0D; wdata = 16'h801E; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R8", rdata, 16'h0011);
    model[6] = 16'h801E;
    do_read(7'h0C, v);
    check("R8", v, 16'h801E);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule